// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit executes the single-bit instructions of a processor datapath: it looks at one bit of an operand, reports whether that bit was clear, and optionally flips, clears or sets it. The caller supplies a bit number, the target operand, a two-bit operation code, a flag telling whether the target is a full-width data register or a memory byte, and a flag telling whether the bit number came from an immediate field or from a register. The unit returns the modified operand, a write-back enable, the new zero flag and the number of bus cycles the instruction is charged.

Every accepted request produces one registered result exactly one clock later, so a new request may be presented on every cycle. The bit number wraps to the width of the target: modulo 32 for a register target and modulo 8 for a memory byte. The zero flag always reflects the bit as it was before any change. Address calculation, bus traffic and the other condition flags belong to the surrounding core.

Top module: `btm_unit`

## Requirements
- R1: While reset is held and after its release before any request, rsp_valid, rsp_wb, rsp_z, rsp_value and rsp_cycles are all 0; req_ready is 1 once the internal reset has been released.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1; each accepted request raises rsp_valid for exactly the following clock, and no other clock raises it.
- R3: With the addressed bit index k, the operation code selects: 0 leaves the operand unchanged, 1 inverts bit k, 2 forces bit k to 0, 3 forces bit k to 1; all other bits are copied unchanged.
- R4: When req_is_reg is 1 the operand is all 32 bits of req_operand and k is req_bitnum modulo 32.
- R5: When req_is_reg is 0 the operand is req_operand[7:0], k is req_bitnum modulo 8, and rsp_value[31:8] is 0 whatever req_operand[31:8] holds.
- R6: rsp_z is 1 when bit k of the original operand was 0 and 0 when it was 1, for every operation code.
- R7: rsp_wb is 0 for operation code 0 and 1 for codes 1, 2 and 3.
- R8: With req_imm 0 (bit number from a register), rsp_cycles is 8 for codes 1 and 3; 4 for code 0 and 8 for code 2, each plus 2 when req_is_reg is 1.
- R9: With req_imm 1 (immediate bit number), rsp_cycles is 12 for codes 1 and 3; 8 for code 0 and 12 for code 2, each plus 2 when req_is_reg is 1.
- R10: On clocks with no accepted request, rsp_value, rsp_wb, rsp_z and rsp_cycles keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 2 | Operation: 0 test, 1 toggle, 2 clear, 3 set |
| req_is_reg | input | 1 | 1 = 32-bit register target, 0 = memory byte target |
| req_imm | input | 1 | 1 = bit number came from an immediate field |
| req_bitnum | input | BITNUM_W (8) | Unreduced bit number |
| req_operand | input | DATA_W (32) | Target operand |
| rsp_valid | output | 1 | One-clock pulse marking a new result |
| rsp_value | output | DATA_W (32) | Updated operand |
| rsp_wb | output | 1 | Result must be written back |
| rsp_z | output | 1 | New zero flag |
| rsp_cycles | output | CYC_W (5) | Cycle cost of the instruction |

## Verification
The hardest case to reach is a bit number whose upper bits would select a different bit if the wrap were wrong, applied to a memory target whose operand carries set bits above the byte, on back-to-back requests with no idle cycle between them. The stimulus mixes directed numbers such as 13, 37, 255 and 31 against operands with dirty upper bytes with a long random stream of every combination of operation, target kind and bit-number source, with random gaps of zero to two cycles, so that consecutive results and the hold of outputs across idle cycles are both exercised.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [1:0] {
    OP_TEST   = 2'd0,
    OP_TOGGLE = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_SET    = 2'd3
  } btm_op_e;

  // cycle cost figures
  localparam int unsigned COST_TEST_REGSRC = 4;
  localparam int unsigned COST_MOD_REGSRC  = 8;
  localparam int unsigned COST_IMM_EXTRA   = 4;
  localparam int unsigned COST_WIDE_EXTRA  = 2;

endpackage

// File: rtl/btm_rst_sync.sv
module btm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/btm_bitop.sv
module btm_bitop
  import btm_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MEM_W    = 8,
  parameter int unsigned BITNUM_W = 8
) (
  input  logic [1:0]          op,
  input  logic                is_reg,
  input  logic [BITNUM_W-1:0] bitnum,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W-1:0]   value,
  output logic                z,
  output logic                wb
);

  localparam int unsigned REG_IW = $clog2(DATA_W);
  localparam int unsigned MEM_IW = $clog2(MEM_W);

  logic [REG_IW-1:0] idx;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] opnd;
  logic              unused_bitnum_hi;

  assign unused_bitnum_hi = ^bitnum[BITNUM_W-1:REG_IW];

  // index wraps to the width of the target
  always_comb begin
    if (is_reg) idx = bitnum[REG_IW-1:0];
    else        idx = {{(REG_IW-MEM_IW){1'b0}}, bitnum[MEM_IW-1:0]};
  end

  // memory byte target: only the low MEM_W bits take part
  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      if (g < MEM_W) begin : g_low
        assign opnd[g] = operand[g];
      end else begin : g_high
        assign opnd[g] = operand[g] & is_reg;
      end
      assign mask[g] = (idx == REG_IW'(g));
    end
  endgenerate

  always_comb begin
    z  = ~|(opnd & mask);
    wb = (op != OP_TEST);
    unique case (btm_op_e'(op))
      OP_TEST:   value = opnd;
      OP_TOGGLE: value = opnd ^ mask;
      OP_CLEAR:  value = opnd & ~mask;
      OP_SET:    value = opnd | mask;
      default:   value = opnd;
    endcase
  end

endmodule

// File: rtl/btm_cost.sv
module btm_cost
  import btm_pkg::*;
#(
  parameter int unsigned CYC_W = 5
) (
  input  logic [1:0]       op,
  input  logic             is_reg,
  input  logic             imm,
  output logic [CYC_W-1:0] cycles
);

  logic [CYC_W-1:0] base;
  logic [CYC_W-1:0] imm_add;
  logic [CYC_W-1:0] wide_add;

  always_comb begin
    if (op == OP_TEST) base = CYC_W'(COST_TEST_REGSRC);
    else               base = CYC_W'(COST_MOD_REGSRC);
    imm_add  = imm ? CYC_W'(COST_IMM_EXTRA) : '0;
    // wide register targets pay extra only for test and clear
    wide_add = (is_reg && (op == OP_TEST || op == OP_CLEAR))
               ? CYC_W'(COST_WIDE_EXTRA) : '0;
    cycles   = base + imm_add + wide_add;
  end

endmodule

// File: rtl/btm_unit.sv
module btm_unit
  import btm_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MEM_W    = 8,
  parameter int unsigned BITNUM_W = 8,
  parameter int unsigned CYC_W    = 5,
  parameter int unsigned RST_STG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic                req_is_reg,
  input  logic                req_imm,
  input  logic [BITNUM_W-1:0] req_bitnum,
  input  logic [DATA_W-1:0]   req_operand,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_value,
  output logic                rsp_wb,
  output logic                rsp_z,
  output logic [CYC_W-1:0]    rsp_cycles
);

  logic              rst_int_n;
  logic              accept;
  logic [DATA_W-1:0] value_d;
  logic              z_d;
  logic              wb_d;
  logic [CYC_W-1:0]  cyc_d;

  logic              valid_q;
  logic [DATA_W-1:0] value_q;
  logic              z_q;
  logic              wb_q;
  logic [CYC_W-1:0]  cyc_q;

  btm_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  btm_bitop #(.DATA_W(DATA_W), .MEM_W(MEM_W), .BITNUM_W(BITNUM_W)) u_bitop (
    .op      (req_op),
    .is_reg  (req_is_reg),
    .bitnum  (req_bitnum),
    .operand (req_operand),
    .value   (value_d),
    .z       (z_d),
    .wb      (wb_d)
  );

  btm_cost #(.CYC_W(CYC_W)) u_cost (
    .op     (req_op),
    .is_reg (req_is_reg),
    .imm    (req_imm),
    .cycles (cyc_d)
  );

  always_comb begin
    req_ready = rst_int_n;
    accept    = req_valid & req_ready;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) valid_q <= 1'b0;
    else            valid_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      value_q <= '0;
      z_q     <= 1'b0;
      wb_q    <= 1'b0;
      cyc_q   <= '0;
    end else if (accept) begin
      value_q <= value_d;
      z_q     <= z_d;
      wb_q    <= wb_d;
      cyc_q   <= cyc_d;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_value  = value_q;
  assign rsp_z      = z_q;
  assign rsp_wb     = wb_q;
  assign rsp_cycles = cyc_q;

endmodule

// File: rtl/btm_unit_chk.sv
module btm_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MEM_W  = 8,
  parameter int unsigned CYC_W  = 5
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              req_is_reg,
  input logic              req_imm,
  input logic [DATA_W-1:0] req_operand,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_value,
  input logic              rsp_wb,
  input logic              rsp_z,
  input logic [CYC_W-1:0]  rsp_cycles
);

  p_rsp_has_req_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $past(req_valid));

  p_req_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(req_valid) && $past(rst_int_n)) |-> rsp_valid);

  p_test_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && $past(req_op) == 2'd0) |-> (!rsp_wb && rsp_value == $past(req_operand)) || !$past(req_is_reg));

  p_toggle_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && $past(req_op) == 2'd1 && $past(req_is_reg)) |->
      $countones(rsp_value ^ $past(req_operand)) == 1);

  p_clear_no_new_ones_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && $past(req_op) == 2'd2 && $past(req_is_reg)) |->
      ((rsp_value & ~$past(req_operand)) == '0 && rsp_wb));

  p_set_z_matches_change_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && $past(req_op) == 2'd3 && $past(req_is_reg)) |->
      ((rsp_value != $past(req_operand)) == rsp_z));

  p_mem_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && !$past(req_is_reg)) |-> rsp_value[DATA_W-1:MEM_W] == '0);

  p_toggle_cost_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rsp_valid && $past(req_op) == 2'd1) |->
      rsp_cycles == ($past(req_imm) ? CYC_W'(12) : CYC_W'(8)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!rsp_valid && $past(rst_int_n)) |-> ($stable(rsp_value) && $stable(rsp_z) && $stable(rsp_cycles)));

endmodule

bind btm_unit btm_unit_chk #(.DATA_W(DATA_W), .MEM_W(MEM_W), .CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_is_reg  (req_is_reg),
  .req_imm     (req_imm),
  .req_operand (req_operand),
  .rsp_valid   (rsp_valid),
  .rsp_value   (rsp_value),
  .rsp_wb      (rsp_wb),
  .rsp_z       (rsp_z),
  .rsp_cycles  (rsp_cycles)
);

// File: tb/tb_btm_unit.sv
module tb_btm_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int BITNUM_W   = 8;
  localparam int CYC_W      = 5;

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic                req_ready;
  logic [1:0]          req_op;
  logic                req_is_reg;
  logic                req_imm;
  logic [BITNUM_W-1:0] req_bitnum;
  logic [DATA_W-1:0]   req_operand;
  logic                rsp_valid;
  logic [DATA_W-1:0]   rsp_value;
  logic                rsp_wb;
  logic                rsp_z;
  logic [CYC_W-1:0]    rsp_cycles;

  typedef struct {
    logic [DATA_W-1:0] value;
    logic              z;
    logic              wb;
    int                cyc;
    int                due;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks;
  int   n_errors;
  int   cyc_cnt;
  logic [DATA_W-1:0] last_value;
  logic last_z;
  int   last_cyc;
  bit   done;

  btm_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_is_reg(req_is_reg), .req_imm(req_imm),
    .req_bitnum(req_bitnum), .req_operand(req_operand),
    .rsp_valid(rsp_valid), .rsp_value(rsp_value), .rsp_wb(rsp_wb),
    .rsp_z(rsp_z), .rsp_cycles(rsp_cycles)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic is_reg, input logic imm,
                                 input logic [BITNUM_W-1:0] bn, input logic [DATA_W-1:0] opd);
    exp_t e;
    int k;
    logic [DATA_W-1:0] v;
    logic [DATA_W-1:0] m;
    if (is_reg) begin k = int'(bn) % 32; v = opd; end
    else begin k = int'(bn) % 8; v = {24'h0, opd[7:0]}; end
    m = 32'h1 << k;
    e.z  = (v[k] == 1'b0);
    e.wb = (op != 2'd0);
    case (op)
      2'd1: v = v ^ m;
      2'd2: v = v & ~m;
      2'd3: v = v | m;
      default: ;
    endcase
    e.value = v;
    if (op == 2'd1 || op == 2'd3) e.cyc = 8;
    else e.cyc = (op == 2'd0 ? 4 : 8) + (is_reg ? 2 : 0);
    if (imm) e.cyc += 4;
    e.due = 0;
    return e;
  endfunction

  // driver: one request per call, on a falling edge
  task automatic send(input logic [1:0] op, input logic is_reg, input logic imm,
                      input logic [BITNUM_W-1:0] bn, input logic [DATA_W-1:0] opd, input int gap);
    exp_t e;
    @(negedge clk);
    e = model(op, is_reg, imm, bn, opd);
    e.due = cyc_cnt + 1;
    exp_q.push_back(e);
    req_valid = 1'b1; req_op = op; req_is_reg = is_reg; req_imm = imm;
    req_bitnum = bn; req_operand = opd;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_operand = 32'hDEAD_BEEF;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected rsp_valid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.due == cyc_cnt, "R2 timing", cyc_cnt, e.due);
          check(rsp_value == e.value, "R3/R4/R5 value", rsp_value, e.value);
          check(rsp_z == e.z, "R6 z flag", rsp_z, e.z);
          check(rsp_wb == e.wb, "R7 write-back", rsp_wb, e.wb);
          check(int'(rsp_cycles) == e.cyc, "R8/R9 cycles", rsp_cycles, e.cyc);
          last_value = e.value; last_z = e.z; last_cyc = e.cyc;
        end
      end else if (exp_q.size() != 0 && exp_q[0].due == cyc_cnt) begin
        check(1'b0, "R2 missing rsp_valid", 0, 1);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0; cyc_cnt = 0; done = 1'b0;
    req_valid = 1'b0; req_op = 2'd0; req_is_reg = 1'b0; req_imm = 1'b0;
    req_bitnum = '0; req_operand = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0 && rsp_value == '0 && rsp_wb == 1'b0 && rsp_z == 1'b0
          && rsp_cycles == '0, "R1 outputs in reset", rsp_value, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0 && rsp_value == '0 && rsp_cycles == '0, "R1 idle after reset", rsp_value, 0);

    // directed: wrap and memory byte cases
    send(2'd0, 1'b1, 1'b0, 8'd37, 32'h0000_0020, 0);   // R4 37 mod 32 = 5, bit set
    send(2'd1, 1'b0, 1'b0, 8'd13, 32'hFFFF_FF00, 0);   // R5 13 mod 8 = 5, dirty upper bytes
    send(2'd3, 1'b0, 1'b1, 8'd255, 32'hA5A5_A500, 0);  // R5 255 mod 8 = 7
    send(2'd2, 1'b1, 1'b1, 8'd31, 32'hFFFF_FFFF, 0);   // R3 clear top bit
    send(2'd3, 1'b1, 1'b0, 8'd63, 32'h0, 1);           // R4 63 mod 32 = 31
    send(2'd0, 1'b0, 1'b1, 8'd8, 32'h0000_01FE, 1);    // R6 bit 0 clear, R9 cost 8
    send(2'd2, 1'b0, 1'b0, 8'd0, 32'h0000_00FF, 0);    // R8 cost 8 mem
    send(2'd0, 1'b1, 1'b1, 8'd0, 32'h1, 2);            // R9 cost 10

    // random stream
    for (int i = 0; i < 400; i++) begin
      send(2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), $urandom, int'($urandom % 3));
    end

    repeat (3) @(negedge clk);
    // R10: outputs hold across idle cycles
    for (int i = 0; i < 3; i++) begin
      check(rsp_valid == 1'b0, "R10 no pulse while idle", rsp_valid, 0);
      check(rsp_value == last_value && rsp_z == last_z && int'(rsp_cycles) == last_cyc,
            "R10 hold", rsp_value, last_value);
      @(negedge clk);
    end
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule